// File: doc/BRIEF.md
# SMBus Byte Shifter with Own-Address Match

This block is the byte-wide data path of a two-wire serial interface. One shift register drives the serial data line and samples it in the same operation. After each byte it therefore holds the byte that actually appeared on the bus. This is true whether the block was transmitting, receiving, or lost arbitration partway through a byte. A bit-level controller outside the block supplies single-cycle strobes for the clock-line edges, START detection, arbitration loss and the start of a master transfer. The block counts eight bits and raises a byte-complete flag. It then freezes until the host clears that flag.

While the block is a slave, it compares the first byte after each START with a host-programmed own address. It reports a hit on the own address or on the general-call address as separate flags, together with the received read/write bit. Bit 0 of the address register decides whether general call is honoured. The host may write the data register only when no byte is in flight. Writes at any other time are dropped.

Top module: `smbsh_top`

## Requirements
- R1: After reset the data register reads 0x00, the address register reads 0x00, and `si`, `sda_out`, `is_master`, `match_own`, `match_gc` and `match_rw` are all 0.
- R2: `sda_out` always presents bit 7 of the data register. Each accepted `scl_fall` shifts the register left by one, so a loaded byte leaves most significant bit first.
- R3: Each accepted `scl_rise` samples `sda_in`, and the following `scl_fall` shifts that sample into bit 0. After eight bit periods the data register equals the eight bus bits, with the first one sampled in bit 7. This holds even while the block is transmitting.
- R4: `si` goes to 1 in the cycle after the eighth accepted `scl_fall` since START or enable, and stays 0 before that. `si_clr` returns it to 0. While `si` is 1, `scl_rise` and `scl_fall` change neither the data register nor `sda_out`.
- R5: `start_master` makes `is_master` 1. `arb_lost` or a low `en` makes it 0 in the next cycle. Arbitration loss does not reload or disturb the data register, so the byte still ends holding the bus value.
- R6: A data-register write (`dat_we`) takes effect when `si` is 1 or `en` is 0. It is ignored when `en` is 1 and `si` is 0. The address register accepts every write and reads back what was written.
- R7: When the first byte after `start_det` completes while the block is slave, `match_own` becomes 1 if received bits 7:1 equal address-register bits 7:1 and are not all zero. `match_rw` takes received bit 0.
- R8: When that byte has bits 7:1 all zero, `match_gc` becomes 1 only if address-register bit 0 is 1. Otherwise no match flag is raised.
- R9: An address byte that completes while `is_master` is 1 raises neither match flag.
- R10: `start_det` restarts the bit count at zero and clears all three match flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Interface enable |
| scl_rise | input | 1 | Strobe: clock line rose, sample data line |
| scl_fall | input | 1 | Strobe: clock line fell, shift to next bit |
| sda_in | input | 1 | Sampled data-line level |
| start_det | input | 1 | Strobe: START condition seen |
| start_master | input | 1 | Strobe: block begins a transfer as master |
| arb_lost | input | 1 | Strobe: arbitration lost |
| dat_we | input | 1 | Host write strobe for the data register |
| dat_wdata | input | 8 | Host write data for the data register |
| dat_rdata | output | 8 | Data register contents |
| adr_we | input | 1 | Host write strobe for the address register |
| adr_wdata | input | 8 | Own address in bits 7:1, general-call enable in bit 0 |
| adr_rdata | output | 8 | Address register contents |
| si_clr | input | 1 | Strobe: clear byte-complete flag |
| si | output | 1 | Byte-complete flag |
| sda_out | output | 1 | Bit to drive on the data line |
| is_master | output | 1 | 1 while the block acts as master |
| match_own | output | 1 | Address byte matched own address |
| match_gc | output | 1 | Address byte matched general call |
| match_rw | output | 1 | Read/write bit of the last address byte |

## Verification
The embedded properties assume that every strobe lasts one cycle. They also assume that `scl_rise` and `scl_fall` never coincide, that `start_det` never coincides with `scl_fall`, and that `arb_lost` arrives only with an `scl_rise` while the block is master. The stimulus issues each bit as a fixed rise-then-fall pair, through tasks that set one strobe per cycle. It asserts `arb_lost` only on the rise where the block drove a 1 and the modelled wired-AND bus carried a 0. It writes the data register only with the block disabled or with `si` set, except in the one check that deliberately targets a blocked write.

// File: rtl/smbsh_pkg.sv
package smbsh_pkg;
  localparam int SMBSH_DW = 8;

  typedef struct packed {
    logic own;
    logic gc;
    logic rw;
  } smbsh_match_t;
endpackage

// File: rtl/smbsh_shifter.sv
module smbsh_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  input  logic          start_det,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          si_clr,
  output logic [DW-1:0] dat_q,
  output logic          si_q,
  output logic          done_q
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q;
  logic          samp_q;
  logic          shift_ok;
  logic          rise_ok;
  logic          fall_ok;
  logic          wr_ok;
  logic          last_bit;

  assign shift_ok = en & ~si_q;
  assign rise_ok  = shift_ok & scl_rise;
  assign fall_ok  = shift_ok & scl_fall & ~start_det;
  assign wr_ok    = cpu_we & (si_q | ~en);
  assign last_bit = fall_ok & (cnt_q == LAST);

  // bit position within the byte
  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!en || start_det) cnt_q <= '0;
    else if (fall_ok)        cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
  end

  // line sample held from rise to fall
  always_ff @(posedge clk) begin
    if (!rst_n)       samp_q <= 1'b0;
    else if (rise_ok) samp_q <= sda_in;
  end

  // single register: outgoing bit leaves at the top, sampled bit enters at the bottom
  always_ff @(posedge clk) begin
    if (!rst_n)       dat_q <= '0;
    else if (wr_ok)   dat_q <= cpu_wdata;
    else if (fall_ok) dat_q <= {dat_q[DW-2:0], samp_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        si_q <= 1'b0;
    else if (si_clr)   si_q <= 1'b0;
    else if (last_bit) si_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last_bit;
  end

  a_r4_si_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_q) |-> $past(scl_fall));
  a_r4_frozen_when_si: assert property (@(posedge clk) disable iff (!rst_n)
    (si_q && !cpu_we) |=> $stable(dat_q));
  a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !si_q && cpu_we && !scl_fall) |=> $stable(dat_q));
  a_r4_done_with_si: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> si_q || $past(si_clr) == 1'b0 && si_q);
endmodule

// File: rtl/smbsh_role.sv
module smbsh_role (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_master,
  input  logic arb_lost,
  output logic is_master
);
  always_ff @(posedge clk) begin
    if (!rst_n)               is_master <= 1'b0;
    else if (arb_lost || !en) is_master <= 1'b0;
    else if (start_master)    is_master <= 1'b1;
  end

  a_r5_drop_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !is_master);
endmodule

// File: rtl/smbsh_addr_match.sv
module smbsh_addr_match
  import smbsh_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          done,
  input  logic          is_master,
  input  logic [DW-1:0] rx,
  input  logic          adr_we,
  input  logic [DW-1:0] adr_wdata,
  output logic [DW-1:0] adr_q,
  output smbsh_match_t  hit_q
);
  localparam int AW = DW - 1;

  logic         pend_q;
  logic [AW-1:0] rx_addr;
  logic [AW-1:0] own_addr;
  logic         rx_zero;
  smbsh_match_t hit_d;

  assign rx_addr  = rx[DW-1:1];
  assign own_addr = adr_q[DW-1:1];
  assign rx_zero  = (rx_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      adr_q <= '0;
    else if (adr_we) adr_q <= adr_wdata;
  end

  // next byte after START is the address byte
  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (start_det) pend_q <= 1'b1;
    else if (done)      pend_q <= 1'b0;
  end

  always_comb begin
    hit_d.own = ~is_master & ~rx_zero & (rx_addr == own_addr);
    hit_d.gc  = ~is_master & rx_zero & adr_q[0];
    hit_d.rw  = ~is_master & rx[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              hit_q <= '0;
    else if (start_det)      hit_q <= '0;
    else if (done && pend_q) hit_q <= hit_d;
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_q.own && hit_q.gc));
  a_r8_gc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q.gc) |-> $past(adr_q[0]));
  a_r9_master_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hit_q.own) || $rose(hit_q.gc)) |-> !$past(is_master));
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (hit_q == '0));
endmodule

// File: rtl/smbsh_top.sv
module smbsh_top
  import smbsh_pkg::*;
#(
  parameter int DW = SMBSH_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  input  logic          start_det,
  input  logic          start_master,
  input  logic          arb_lost,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  input  logic          adr_we,
  input  logic [DW-1:0] adr_wdata,
  output logic [DW-1:0] adr_rdata,
  input  logic          si_clr,
  output logic          si,
  output logic          sda_out,
  output logic          is_master,
  output logic          match_own,
  output logic          match_gc,
  output logic          match_rw
);
  logic [DW-1:0] dat_q;
  logic          done;
  smbsh_match_t  hit;

  smbsh_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_in    (sda_in),
    .start_det (start_det),
    .cpu_we    (dat_we),
    .cpu_wdata (dat_wdata),
    .si_clr    (si_clr),
    .dat_q     (dat_q),
    .si_q      (si),
    .done_q    (done)
  );

  smbsh_role u_role (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .start_master (start_master),
    .arb_lost     (arb_lost),
    .is_master    (is_master)
  );

  smbsh_addr_match #(.DW(DW)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .done      (done),
    .is_master (is_master),
    .rx        (dat_q),
    .adr_we    (adr_we),
    .adr_wdata (adr_wdata),
    .adr_q     (adr_rdata),
    .hit_q     (hit)
  );

  assign dat_rdata = dat_q;
  assign sda_out   = dat_q[DW-1];
  assign match_own = hit.own;
  assign match_gc  = hit.gc;
  assign match_rw  = hit.rw;

  a_r2_line_tracks_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !scl_fall && !dat_we) |=> $stable(sda_out));
endmodule

// File: tb/smbsh_top_bench.sv
`timescale 1ns/1ps
module smbsh_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;
  logic       start_det = 1'b0, start_master = 1'b0, arb_lost = 1'b0;
  logic       dat_we = 1'b0, adr_we = 1'b0, si_clr = 1'b0;
  logic [7:0] dat_wdata = '0, adr_wdata = '0;
  logic [7:0] dat_rdata, adr_rdata;
  logic       si, sda_out, is_master, match_own, match_gc, match_rw;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  smbsh_top u_smbsh_top (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_in(sda_in), .start_det(start_det), .start_master(start_master),
    .arb_lost(arb_lost), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .adr_we(adr_we), .adr_wdata(adr_wdata),
    .adr_rdata(adr_rdata), .si_clr(si_clr), .si(si), .sda_out(sda_out),
    .is_master(is_master), .match_own(match_own), .match_gc(match_gc),
    .match_rw(match_rw)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_period(input logic b, input logic lose);
    @(negedge clk); sda_in = b; scl_rise = 1'b1; arb_lost = lose;
    @(negedge clk); scl_rise = 1'b0; arb_lost = 1'b0; scl_fall = 1'b1;
    @(negedge clk); scl_fall = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_period(b[i], 1'b0);
  endtask

  task automatic p_start();   @(negedge clk); start_det = 1'b1;    @(negedge clk); start_det = 1'b0;    endtask
  task automatic p_master();  @(negedge clk); start_master = 1'b1; @(negedge clk); start_master = 1'b0; endtask
  task automatic p_siclr();   @(negedge clk); si_clr = 1'b1;       @(negedge clk); si_clr = 1'b0;       endtask
  task automatic w_dat(input logic [7:0] d); @(negedge clk); dat_we = 1'b1; dat_wdata = d; @(negedge clk); dat_we = 1'b0; endtask
  task automatic w_adr(input logic [7:0] d); @(negedge clk); adr_we = 1'b1; adr_wdata = d; @(negedge clk); adr_we = 1'b0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] tx, oth, bus, rx, cfg, held;
    logic       lost, b, lose, e_own, e_gc, e_rw;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dat_rdata == 8'h00, "R1 data", dat_rdata, 0);
    chk(adr_rdata == 8'h00, "R1 addr", adr_rdata, 0);
    chk({si, sda_out, is_master} == 3'b000, "R1 status", {si, sda_out, is_master}, 0);
    chk({match_own, match_gc, match_rw} == 3'b000, "R1 match", {match_own, match_gc, match_rw}, 0);

    // R6 write blocked while enabled and idle, accepted when disabled
    en = 1'b1;
    w_dat(8'h5A);
    @(negedge clk);
    chk(dat_rdata == 8'h00, "R6 blocked write", dat_rdata, 8'h00);
    en = 1'b0;
    w_dat(8'h5A);
    chk(dat_rdata == 8'h5A, "R6 disabled write", dat_rdata, 8'h5A);

    // own address 0x50, general call on
    w_adr(8'hA1);
    chk(adr_rdata == 8'hA1, "R6 addr readback", adr_rdata, 8'hA1);

    // master transmit over a wired-AND bus, with and without contention
    for (int v = 0; v < 256; v++) begin
      tx  = v[7:0];
      oth = (v < 128) ? 8'hFF : 8'(v * 29 + 7);
      en = 1'b0;
      w_dat(tx);
      en = 1'b1;
      p_master();
      chk(is_master == 1'b1, "R5 master set", is_master, 1);
      p_start();
      lost = 1'b0;
      for (int i = 7; i >= 0; i--) begin
        if (!lost) chk(sda_out == tx[i], "R2 msb first", sda_out, tx[i]);
        if (i == 0) chk(si == 1'b0, "R4 si before eighth", si, 0);
        b    = lost ? oth[i] : (tx[i] & oth[i]);
        lose = !lost && tx[i] && !oth[i];
        if (lose) lost = 1'b1;
        bus[i] = b;
        bit_period(b, lose);
      end
      @(negedge clk);
      chk(si == 1'b1, "R4 si after eighth", si, 1);
      chk(dat_rdata == bus, "R3 R5 bus byte held", dat_rdata, bus);
      chk(is_master == !lost, "R5 role after byte", is_master, !lost);
      e_own = lost && (bus[7:1] == 7'h50);
      e_gc  = lost && (bus[7:1] == 7'h00);
      chk(match_own == e_own && match_gc == e_gc, "R9 match while master",
          {match_own, match_gc}, {e_own, e_gc});
      p_siclr();
      chk(si == 1'b0, "R4 si cleared", si, 0);
    end

    // slave address sweep over every address-register value
    en = 1'b0; @(negedge clk); en = 1'b1;
    for (int c = 0; c < 256; c++) begin
      cfg = c[7:0];
      w_adr(cfg);
      chk(adr_rdata == cfg, "R6 addr write", adr_rdata, cfg);
      for (int k = 0; k < 4; k++) begin
        case (k)
          0: rx = {cfg[7:1], cfg[1]};
          1: rx = {cfg[7:1] ^ 7'h2A, 1'b0};
          2: rx = 8'h00;
          default: rx = 8'h01;
        endcase
        p_start();
        chk({match_own, match_gc, match_rw} == 3'b000, "R10 start clears", {match_own, match_gc, match_rw}, 0);
        send_byte(rx);
        @(negedge clk);
        e_own = (rx[7:1] == cfg[7:1]) && (rx[7:1] != 7'h00);
        e_gc  = (rx[7:1] == 7'h00) && cfg[0];
        e_rw  = rx[0];
        chk(match_own == e_own, "R7 own match", match_own, e_own);
        chk(match_gc == e_gc, "R8 general call", match_gc, e_gc);
        chk(match_rw == e_rw, "R7 rw bit", match_rw, e_rw);
        chk(dat_rdata == rx, "R3 slave receive", dat_rdata, rx);
        if (c == 8'h55 && k == 0) begin
          held = dat_rdata;
          bit_period(~held[7], 1'b0);
          bit_period(held[7], 1'b0);
          chk(dat_rdata == held, "R4 frozen data", dat_rdata, held);
          chk(sda_out == held[7], "R4 frozen line", sda_out, held[7]);
          chk(si == 1'b1, "R4 si held", si, 1);
        end
        p_siclr();
      end
    end

    // R10 partial byte then restart
    p_start();
    for (int i = 0; i < 3; i++) bit_period(1'b1, 1'b0);
    p_start();
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) chk(si == 1'b0, "R10 count restarted", si, 0);
      bit_period(tx[0] ^ (i[0]), 1'b0);
      bus[i] = tx[0] ^ (i[0]);
    end
    @(negedge clk);
    chk(si == 1'b1, "R10 si after full byte", si, 1);
    chk(dat_rdata == bus, "R10 byte after restart", dat_rdata, bus);

    // R5 disable drops master role
    p_siclr();
    p_master();
    en = 1'b0; @(negedge clk); @(negedge clk);
    chk(is_master == 1'b0, "R5 disable clears role", is_master, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule